// File: doc/BRIEF.md
# Stepping-Character Serial Transmitter

This block drives an asynchronous serial line with a stream of printable characters and needs no data input. Once reset is released it sends the digit '0' (0x30) by itself. After that, each press of a pushbutton moves the character on by one and sends the new one. The step after 'z' (0x7a) goes back to '0'. The clock is 50 MHz and the line runs at 115200 baud, so one bit lasts 434 system clocks. That count is a parameter and can be changed.

Three parts make up the block. The button input is synchronised and reduced to one pulse per press. A bit-time divider runs only while a frame is on the line. A framing state machine shifts out a low start bit, eight data bits least significant first, and a high stop bit. A small sequencer picks each character and shows on an 8-bit bus the character of the most recent frame. A press that comes in during a frame is stored, at most one deep, and served as soon as the stop bit ends.

Top module: `uart_step_tx`

## Requirements
- R1: While reset is held, and whenever no frame is in progress, `txd` is 1 and `busy` is 0. During reset `last_char` reads 0x00.
- R2: A frame is a 0 start bit, then eight data bits with bit 0 first, then a 1 stop bit. Each bit holds `txd` for exactly CLKS_PER_BIT clocks (434 by default).
- R3: With no button activity, the first frame after reset release carries 0x30. Its start bit begins on the first clock edge after release.
- R4: A press is served while no frame is running. It sends the previously sent character plus one.
- R5: The character that follows 0x7a is 0x30. All characters sent lie in 0x30..0x7a.
- R6: `last_char` takes the value of a frame's character on the clock edge where that frame's start bit begins. It holds that value until the next frame starts.
- R7: `busy` is 1 from the first clock of the start bit through the last clock of the stop bit. It goes to 0 on the clock after the stop bit ends.
- R8: A press during a frame is held. Its frame starts one clock after the current stop bit ends. Further presses during the same frame are dropped, so at most one press waits.
- R9: A rising edge on `btn` counts as one press however long the button stays high. It takes effect after SYNC_STAGES synchroniser flops plus one edge-detect flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn | input | 1 | Raw pushbutton level, high when pressed |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | High while a frame is on the line |
| last_char | output | 8 | Character of the most recently started frame |

## Verification
The bench decodes every frame at mid-bit. A design that sent bits in reverse order, or made one bit period too short or too long, drifts off the sampling points and reports wrong bytes or a missing stop bit.

Three button patterns get their own tests: a burst of three presses inside one frame, a button held across a whole frame, and a character stepped up to 'z'. A design that queued every press, or re-fired on a level, would put out extra frames in the quiet window that follows. A design that wrapped at the wrong place would send '{' instead of '0'.

The automatic frame after reset is checked without any press. A design that waited for the button would time out at this point.

// File: rtl/uart_step_pkg.sv
package uart_step_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;

  // Next character in the wrapping range [lo, hi].
  function automatic logic [7:0] step_char(input logic [7:0] cur,
                                           input logic [7:0] lo,
                                           input logic [7:0] hi);
    if (cur >= hi) return lo;
    else           return cur + 8'd1;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int cnt_width(input int n);
    if (n <= 2) return 1;
    else        return $clog2(n);
  endfunction

endpackage

// File: rtl/ust_btn_edge.sv
module ust_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic press_o
);

  logic synced;
  logic prev_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= btn_i;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], btn_i};
      end
      assign synced = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign press_o = synced & ~prev_q;

  // R9: a press is a single-cycle event
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/ust_baud_div.sv
module ust_baud_div #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  import uart_step_pkg::*;

  localparam int CNT_W = cnt_width(CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_LAST);
  assign tick_o = run_i & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R2: no bit-time tick while the line is idle
  a_r2_no_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o);

  generate
    if (CLKS_PER_BIT > 1) begin : g_spacing
      // R2: ticks are separated by at least one cycle
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/ust_frame_tx.sv
module ust_frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              frame_done_o
);
  import uart_step_pkg::*;

  localparam int IDX_W = cnt_width(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            shreg_q <= data_i;
            idx_q   <= '0;
            state_q <= TX_START;
          end
        end
        TX_START: begin
          if (tick_i) state_q <= TX_DATA;
        end
        TX_DATA: begin
          if (tick_i) begin
            shreg_q <= shreg_q >> 1;
            if (idx_q == IDX_LAST) state_q <= TX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        TX_STOP: begin
          if (tick_i) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = shreg_q[0];
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o       = (state_q != TX_IDLE);
  assign frame_done_o = (state_q == TX_STOP) & tick_i;

  // R8: a new frame is only requested while idle
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R2: the first bit of every frame is low
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !txd_o);
  // R2: the last bit of every frame is high
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(txd_o));
  // R7: busy drops exactly after the stop bit completes
  a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(frame_done_o));
  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o);

endmodule

// File: rtl/ust_char_seq.sv
module ust_char_seq #(
  parameter logic [7:0] FIRST_CHAR = 8'h30,
  parameter logic [7:0] LAST_CHAR  = 8'h7a
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press_i,
  input  logic       busy_i,
  output logic       launch_o,
  output logic [7:0] send_char_o,
  output logic [7:0] last_char_o
);
  import uart_step_pkg::*;

  logic       boot_q;
  logic       pend_q;
  logic [7:0] cur_q;
  logic [7:0] last_q;
  logic [7:0] stepped;

  assign stepped     = step_char(cur_q, FIRST_CHAR, LAST_CHAR);
  assign launch_o    = !busy_i && (boot_q || pend_q);
  assign send_char_o = boot_q ? cur_q : stepped;
  assign last_char_o = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      pend_q <= 1'b0;
      cur_q  <= FIRST_CHAR;
      last_q <= 8'h00;
    end else begin
      if (launch_o) begin
        boot_q <= 1'b0;
        last_q <= send_char_o;
        if (!boot_q) begin
          cur_q  <= stepped;
          pend_q <= press_i;
        end else begin
          pend_q <= pend_q | press_i;
        end
      end else begin
        pend_q <= pend_q | press_i;
      end
    end
  end

  // R5: the character stays inside the wrapping range
  a_r5_char_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q >= FIRST_CHAR) && (cur_q <= LAST_CHAR));
  // R7: a frame begins only after a launch one cycle earlier
  a_r7_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> $past(launch_o));
  // R6: shown character changes only when a frame is launched
  a_r6_last_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_o |=> $stable(last_char_o));

endmodule

// File: rtl/uart_step_tx.sv
module uart_step_tx #(
  parameter int         CLKS_PER_BIT = 434,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] FIRST_CHAR   = 8'h30,
  parameter logic [7:0] LAST_CHAR    = 8'h7a
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn,
  output logic       txd,
  output logic       busy,
  output logic [7:0] last_char
);

  logic       press;
  logic       launch;
  logic [7:0] send_char;
  logic       bit_tick;
  logic       frame_done;

  ust_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_i   (btn),
    .press_o (press)
  );

  ust_char_seq #(.FIRST_CHAR(FIRST_CHAR), .LAST_CHAR(LAST_CHAR)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .press_i     (press),
    .busy_i      (busy),
    .launch_o    (launch),
    .send_char_o (send_char),
    .last_char_o (last_char)
  );

  ust_baud_div #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .tick_o (bit_tick)
  );

  ust_frame_tx #(.DATA_W(8)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (launch),
    .data_i       (send_char),
    .tick_i       (bit_tick),
    .txd_o        (txd),
    .busy_o       (busy),
    .frame_done_o (frame_done)
  );

  // R8: a queued frame starts right after the previous one ends
  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
  // R1: line high whenever no frame runs
  a_r1_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

endmodule

// File: tb/test_uart_step_tx.sv
`timescale 1ns/1ps
module test_uart_step_tx;

  localparam int CPB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn = 1'b0;
  logic       txd;
  logic       busy;
  logic [7:0] last_char;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ch;

  always #2.5 clk = ~clk;

  uart_step_tx #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) i_uart_step_tx (
    .clk(clk), .rst_n(rst_n), .btn(btn),
    .txd(txd), .busy(busy), .last_char(last_char)
  );

  // hold cycles (upper byte), expected character (lower byte)
  localparam logic [15:0] VEC [8] = '{
    {8'd1,   8'h31}, {8'd2,  8'h32}, {8'd3, 8'h33}, {8'd7, 8'h34},
    {8'd150, 8'h35}, {8'd1,  8'h36}, {8'd40, 8'h37}, {8'd4, 8'h38}
  };

  function automatic logic [7:0] ref_next(input logic [7:0] c);
    logic [8:0] t;
    t = {1'b0, c} + 9'd1;
    return (t > 9'h07a) ? 8'h30 : t[7:0];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic press(input int hold);
    @(negedge clk) btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] exp, input string tag);
    logic [7:0] got;
    int n;
    n = 0;
    got = '0;
    do begin
      @(negedge clk);
      n++;
    end while (txd !== 1'b0 && n < 400);
    if (txd !== 1'b0) begin
      chk(32'd0, 32'd1, {tag, " no frame started"});
      return;
    end
    chk(busy, 1'b1, "R7 busy at first start cycle");
    chk(last_char, exp, "R6 last_char at frame start");
    repeat (CPB/2) @(negedge clk);
    chk(txd, 1'b0, "R2 start bit mid");
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      got[i] = txd;
    end
    repeat (CPB) @(negedge clk);
    chk(txd, 1'b1, "R2 stop bit");
    chk(busy, 1'b1, "R7 busy during stop");
    chk(got, exp, tag);
    repeat (CPB/2) @(negedge clk);
    chk(busy, 1'b0, "R7 busy low after stop");
  endtask

  task automatic expect_quiet(input int cyc, input string tag);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0) seen = 1'b1;
    end
    chk(seen, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R1..): actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(txd, 1'b1, "R1 txd in reset");
    chk(busy, 1'b0, "R1 busy in reset");
    chk(last_char, 8'h00, "R1 last_char in reset");
    rst_n = 1'b1;
    // R3 automatic first character
    recv(8'h30, "R3 boot character");
    expect_quiet(120, "R1 idle after boot frame");

    // R4 / R9 table walk
    for (int v = 0; v < 8; v++) begin
      fork
        press(int'(VEC[v][15:8]));
        recv(VEC[v][7:0], "R4 stepped character");
      join
      expect_quiet(100, "R9 one frame per press");
    end

    // R8 queueing: burst of presses inside a frame
    fork
      press(2);
      recv(8'h39, "R4 frame before queue");
      begin
        repeat (25) @(negedge clk);
        press(2);
        press(2);
        press(2);
      end
    join
    recv(8'h3a, "R8 queued frame");
    expect_quiet(200, "R8 extra presses dropped");

    // R5 wrap: step up to 0x7a, then one more
    exp_ch = 8'h3a;
    for (int k = 0; k < 64; k++) begin
      exp_ch = ref_next(exp_ch);
      fork
        press(1);
        recv(exp_ch, "R4 sweep character");
      join
    end
    chk(exp_ch, 8'h7a, "R5 sweep reached top");
    fork
      press(1);
      recv(8'h30, "R5 wrap to 0x30");
    join
    fork
      press(1);
      recv(8'h31, "R5 continue after wrap");
    join
    chk(last_char, 8'h31, "R6 last_char holds after frame");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule